// File: doc/BRIEF.md
# Machine-Mode Double-Trap Controller

This block owns the machine-level trap bookkeeping of a small core: the interrupt-enable pair (current and previous), the previous-privilege field, the modify-privilege bit, and a double-trap guard bit. It also holds the trap vector base, the saved exception PC and the saved cause. When the core reports a trap, the block updates this state and issues a one-cycle redirect with the handler address. Return strobes (machine return, supervisor return and debug return) unwind the state. Software writes the status and vector registers through plain write ports.

The guard bit is set on every trap the block accepts and is cleared by a return. If a second trap arrives while the guard is still set, or while the NMI-enable level is low, the block does not vector. It leaves all trap state untouched and latches a critical error instead. A latched critical error raises a debug-entry request. The cause code of that request depends on a debug control bit: 7 with extended cause 0 when the bit is set, and plain halt (5) when it is clear. The block also forwards halt-group and single-step debug requests, each with its own cause code.

The parameter `DBL_TRAP` selects whether the guard exists. With it off, the guard bit and the debug control bit both read zero, and every trap vectors normally.

Top module: `mdt_trap_ctrl`

## Requirements
- R1: After reset, the status word `st_rd` reads 6'b010000 when `DBL_TRAP`=1 and 6'b000000 when `DBL_TRAP`=0. The status bit layout is: bit0 MIE, bit1 MPIE, bits3:2 MPP, bit4 MDT, bit5 MPRV. After reset, `cetrig_rd`, `crit_err`, `in_debug` and `dbg_req` are also 0.
- R2: A status write stores `st_wd`, with one exception: when the stored MDT is 1, MIE is stored as 0.
- R3: An accepted trap performs all of these updates on one clock edge:
  - it sets MDT to 1;
  - it copies MIE into MPIE;
  - it stores `cur_priv` in MPP;
  - it clears MIE;
  - it stores `trap_epc` in `epc_rd`;
  - it stores {`trap_irq`, `trap_code`} in `cause_rd`, with the interrupt flag in the top bit.
- R4: An accepted trap pulses `redirect` for exactly the one cycle after its edge, with `redirect_pc` set as follows:
  - the base is the vector register with bit 0 cleared;
  - 4×`trap_code` is added to the base only when vector bit 0 is 1 and `trap_irq` is 1.
- R5: With `DBL_TRAP`=1, a trap that arrives while MDT is 1 or `nmi_en` is 0 changes no status, EPC or cause state and produces no redirect. It sets `crit_err` instead.
- R6: `crit_err` stays set until a debug acknowledge and is cleared by it. While `crit_err` is set, or while in debug mode, trap requests are ignored.
- R7: `dbg_req` is raised outside debug mode for three sources, in this priority order:
  - a critical error, with cause 7 when `cetrig_rd` is 1 and cause 5 otherwise;
  - `grp_halt`, with cause 6;
  - `step_done`, with cause 4.
  `dbg_extcause` is always 0. `dbg_ack` enters debug mode and latches the cause in `dbg_last_cause`.
- R8: A machine return clears MDT, copies MPIE into MIE, sets MPIE to 1 and sets MPP to 0.
- R9: A supervisor return clears MDT only when `cur_priv` is 3 (machine). From a lower privilege it leaves MDT unchanged.
- R10: A debug return leaves debug mode. It clears MPRV and MDT only when `ret_priv` is below 3.
- R11: With `DBL_TRAP`=0:
  - `cetrig_rd` stays 0 and writes to it are ignored;
  - MDT reads 0 and status writes to it are ignored;
  - traps are never blocked and `crit_err` stays 0.
- R12: A trap in the same cycle as a status write wins, and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Trap request strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Trap cause code |
| trap_epc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (3 = machine) |
| nmi_en | input | 1 | NMI-enable level |
| mret | input | 1 | Machine return strobe |
| sret | input | 1 | Supervisor return strobe |
| dret | input | 1 | Debug return strobe |
| ret_priv | input | 2 | Privilege that the debug return resumes in |
| st_we | input | 1 | Status write enable |
| st_wd | input | 6 | Status write data |
| tvec_we | input | 1 | Vector base write enable |
| tvec_wd | input | XLEN | Vector base write data |
| cet_we | input | 1 | Critical-error trigger enable write strobe |
| cet_wd | input | 1 | Critical-error trigger enable write data |
| grp_halt | input | 1 | Halt-group debug request |
| step_done | input | 1 | Single-step completed debug request |
| dbg_ack | input | 1 | Debug entry acknowledge |
| st_rd | output | 6 | Status word |
| tvec_rd | output | XLEN | Vector base |
| epc_rd | output | XLEN | Saved trap PC |
| cause_rd | output | CODE_W+1 | Saved cause (interrupt flag in top bit) |
| cetrig_rd | output | 1 | Critical-error trigger enable |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | XLEN | Handler address |
| crit_err | output | 1 | Critical error latched |
| dbg_req | output | 1 | Debug entry request |
| dbg_cause | output | 3 | Cause code of the pending request |
| dbg_extcause | output | 3 | Extended cause of the pending request |
| in_debug | output | 1 | Debug mode active |
| dbg_last_cause | output | 3 | Cause latched at the last debug entry |

## Verification
The bench builds two copies of the block. The first uses `DBL_TRAP`=1 with XLEN 32 and CODE_W 5. It reaches the double-trap blocking, the NMI-low blocking, both critical-error cause codes and the resets and releases of the guard. The second uses `DBL_TRAP`=0. It shows that the guard and the trigger enable vanish, and that back-to-back traps and traps with NMI-enable low vector normally. Vectored and direct bases, interrupt and exception causes, and a trap racing a status write are all driven on the first copy.

// File: rtl/mdt_trap_ctrl.sv
module mdt_trap_ctrl #(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 5,
  parameter bit DBL_TRAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_epc,
  input  logic [1:0]        cur_priv,
  input  logic              nmi_en,
  input  logic              mret,
  input  logic              sret,
  input  logic              dret,
  input  logic [1:0]        ret_priv,
  input  logic              st_we,
  input  logic [5:0]        st_wd,
  input  logic              tvec_we,
  input  logic [XLEN-1:0]   tvec_wd,
  input  logic              cet_we,
  input  logic              cet_wd,
  input  logic              grp_halt,
  input  logic              step_done,
  input  logic              dbg_ack,
  output logic [5:0]        st_rd,
  output logic [XLEN-1:0]   tvec_rd,
  output logic [XLEN-1:0]   epc_rd,
  output logic [CODE_W:0]   cause_rd,
  output logic              cetrig_rd,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              crit_err,
  output logic              dbg_req,
  output logic [2:0]        dbg_cause,
  output logic [2:0]        dbg_extcause,
  output logic              in_debug,
  output logic [2:0]        dbg_last_cause
);

  localparam logic [1:0] PRV_M      = 2'd3;
  localparam logic [1:0] PRV_U      = 2'd0;
  localparam logic [2:0] DC_STEP    = 3'd4;
  localparam logic [2:0] DC_HALT    = 3'd5;
  localparam logic [2:0] DC_GROUP   = 3'd6;
  localparam logic [2:0] DC_EXT     = 3'd7;
  localparam logic [2:0] DX_CRIT    = 3'd0;
  localparam int         PAD_W      = XLEN - CODE_W - 2;

  logic              mie_q, mpie_q, mdt_q, mprv_q;
  logic [1:0]        mpp_q;
  logic [XLEN-1:0]   tvec_q, epc_q, rpc_q;
  logic [CODE_W:0]   cause_q;
  logic              cet_q, crit_q, dbg_q, rdir_q;
  logic [2:0]        dlast_q;

  logic trap_seen, trap_bad, trap_go;
  logic mret_go, sret_go, dret_go, wr_go;
  logic wr_mdt;
  logic ack_go;
  logic [XLEN-1:0] vec_off, handler;

  assign trap_seen = trap_req && !crit_q && !dbg_q;
  assign trap_bad  = trap_seen && DBL_TRAP && (mdt_q || !nmi_en);
  assign trap_go   = trap_seen && !trap_bad;

  assign mret_go = !trap_seen && mret;
  assign sret_go = !trap_seen && !mret && sret;
  assign dret_go = !trap_seen && !mret && !sret && dret && dbg_q;
  assign wr_go   = st_we && !trap_seen && !mret && !sret && !dret_go;

  assign wr_mdt  = DBL_TRAP && st_wd[4];

  assign vec_off = (trap_irq && tvec_q[0]) ? {{PAD_W{1'b0}}, trap_code, 2'b00} : '0;
  assign handler = {tvec_q[XLEN-1:1], 1'b0} + vec_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      mpp_q  <= PRV_U;
      mdt_q  <= DBL_TRAP;
      mprv_q <= 1'b0;
    end else if (trap_go) begin
      mpie_q <= mie_q;
      mie_q  <= 1'b0;
      mpp_q  <= cur_priv;
      mdt_q  <= DBL_TRAP;
    end else if (mret_go) begin
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
      mpp_q  <= PRV_U;
      mdt_q  <= 1'b0;
    end else if (sret_go) begin
      if (cur_priv == PRV_M) mdt_q <= 1'b0;
    end else if (dret_go) begin
      if (ret_priv != PRV_M) begin
        mprv_q <= 1'b0;
        mdt_q  <= 1'b0;
      end
    end else if (wr_go) begin
      mie_q  <= st_wd[0] && !wr_mdt;
      mpie_q <= st_wd[1];
      mpp_q  <= st_wd[3:2];
      mdt_q  <= wr_mdt;
      mprv_q <= st_wd[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      rdir_q  <= 1'b0;
      rpc_q   <= '0;
    end else begin
      rdir_q <= trap_go;
      if (trap_go) begin
        epc_q   <= trap_epc;
        cause_q <= {trap_irq, trap_code};
        rpc_q   <= handler;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tvec_q <= '0;
    else if (tvec_we) tvec_q <= tvec_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cet_q <= 1'b0;
    else if (cet_we && DBL_TRAP)   cet_q <= cet_wd;
  end

  assign dbg_req = !dbg_q && (crit_q || grp_halt || step_done);
  assign ack_go  = dbg_req && dbg_ack;

  always_comb begin
    dbg_extcause = 3'd0;
    if (crit_q) begin
      dbg_cause = cet_q ? DC_EXT : DC_HALT;
      if (cet_q) dbg_extcause = DX_CRIT;
    end else if (grp_halt) begin
      dbg_cause = DC_GROUP;
    end else begin
      dbg_cause = DC_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_q  <= 1'b0;
      dbg_q   <= 1'b0;
      dlast_q <= 3'd0;
    end else begin
      if (trap_bad)     crit_q <= 1'b1;
      else if (ack_go)  crit_q <= 1'b0;
      if (ack_go) begin
        dbg_q   <= 1'b1;
        dlast_q <= dbg_cause;
      end else if (dret_go) begin
        dbg_q   <= 1'b0;
      end
    end
  end

  assign st_rd          = {mprv_q, mdt_q, mpp_q, mpie_q, mie_q};
  assign tvec_rd        = tvec_q;
  assign epc_rd         = epc_q;
  assign cause_rd       = cause_q;
  assign cetrig_rd      = cet_q;
  assign redirect       = rdir_q;
  assign redirect_pc    = rpc_q;
  assign crit_err       = crit_q;
  assign in_debug       = dbg_q;
  assign dbg_last_cause = dlast_q;

  p_mie_off_under_mdt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mdt_q |-> !mie_q);

  p_redirect_follows_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(trap_req));

  p_trap_ignored_when_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && (crit_err || in_debug)) |=> !redirect);

  p_crit_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_err && !dbg_ack) |=> crit_err);

  p_mret_clears_mdt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mret && !trap_req) |=> !st_rd[4]);

  p_extcause_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> (dbg_extcause == 3'd0));

  generate
    if (DBL_TRAP) begin : g_guard_chk
      p_crit_freezes_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crit_err) |-> ($stable(epc_rd) && $stable(cause_rd) && $stable(st_rd) && !redirect));

      p_trap_sets_mdt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !crit_err && !in_debug && !st_rd[4] && nmi_en) |=> (st_rd[4] && !st_rd[0]));

      p_crit_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && crit_err) |-> (dbg_cause == (cetrig_rd ? 3'd7 : 3'd5)));
    end else begin : g_noguard_chk
      p_no_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rd[4] && !crit_err && !cetrig_rd);
    end
  endgenerate

endmodule

// File: tb/mdt_trap_ctrl_bench.sv
module mdt_trap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int CODE_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              trap_req, trap_irq, nmi_en, mret, sret, dret;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0]   trap_epc, tvec_wd;
  logic [1:0]        cur_priv, ret_priv;
  logic              st_we, tvec_we, cet_we, cet_wd, grp_halt, step_done, dbg_ack;
  logic [5:0]        st_wd;

  logic [5:0]        st_rd, n_st_rd;
  logic [XLEN-1:0]   tvec_rd, epc_rd, redirect_pc, n_tvec_rd, n_epc_rd, n_redirect_pc;
  logic [CODE_W:0]   cause_rd, n_cause_rd;
  logic              cetrig_rd, redirect, crit_err, dbg_req, in_debug;
  logic              n_cetrig_rd, n_redirect, n_crit_err, n_dbg_req, n_in_debug;
  logic [2:0]        dbg_cause, dbg_extcause, dbg_last_cause;
  logic [2:0]        n_dbg_cause, n_dbg_extcause, n_dbg_last_cause;

  mdt_trap_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W), .DBL_TRAP(1'b1)) u_mdt_trap_ctrl (
    .clk, .rst_n, .trap_req, .trap_irq, .trap_code, .trap_epc, .cur_priv, .nmi_en,
    .mret, .sret, .dret, .ret_priv, .st_we, .st_wd, .tvec_we, .tvec_wd, .cet_we, .cet_wd,
    .grp_halt, .step_done, .dbg_ack,
    .st_rd, .tvec_rd, .epc_rd, .cause_rd, .cetrig_rd, .redirect, .redirect_pc, .crit_err,
    .dbg_req, .dbg_cause, .dbg_extcause, .in_debug, .dbg_last_cause);

  mdt_trap_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W), .DBL_TRAP(1'b0)) u_mdt_trap_ctrl_nodt (
    .clk, .rst_n, .trap_req, .trap_irq, .trap_code, .trap_epc, .cur_priv, .nmi_en,
    .mret, .sret, .dret, .ret_priv, .st_we, .st_wd, .tvec_we, .tvec_wd, .cet_we, .cet_wd,
    .grp_halt, .step_done, .dbg_ack,
    .st_rd(n_st_rd), .tvec_rd(n_tvec_rd), .epc_rd(n_epc_rd), .cause_rd(n_cause_rd),
    .cetrig_rd(n_cetrig_rd), .redirect(n_redirect), .redirect_pc(n_redirect_pc),
    .crit_err(n_crit_err), .dbg_req(n_dbg_req), .dbg_cause(n_dbg_cause),
    .dbg_extcause(n_dbg_extcause), .in_debug(n_in_debug), .dbg_last_cause(n_dbg_last_cause));

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    trap_req = 0; trap_irq = 0; trap_code = '0; trap_epc = '0; cur_priv = 2'd3; nmi_en = 1;
    mret = 0; sret = 0; dret = 0; ret_priv = 2'd3; st_we = 0; st_wd = '0;
    tvec_we = 0; tvec_wd = '0; cet_we = 0; cet_wd = 0; grp_halt = 0; step_done = 0; dbg_ack = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_st(input logic [5:0] v);
    st_we = 1; st_wd = v; @(negedge clk); st_we = 0;
  endtask

  task automatic wr_tvec(input logic [XLEN-1:0] v);
    tvec_we = 1; tvec_wd = v; @(negedge clk); tvec_we = 0;
  endtask

  task automatic do_trap(input logic irq, input logic [CODE_W-1:0] code,
                         input logic [XLEN-1:0] epc, input logic [1:0] prv);
    trap_req = 1; trap_irq = irq; trap_code = code; trap_epc = epc; cur_priv = prv;
    @(negedge clk);
    trap_req = 0; cur_priv = 2'd3;
  endtask

  task automatic do_ret(input int kind, input logic [1:0] prv, input logic [1:0] rp);
    cur_priv = prv; ret_priv = rp;
    if (kind == 0) mret = 1; else if (kind == 1) sret = 1; else dret = 1;
    @(negedge clk);
    mret = 0; sret = 0; dret = 0; cur_priv = 2'd3; ret_priv = 2'd3;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", st_rd, 6'b010000);
    chk("R1 cetrig", cetrig_rd, 0);
    chk("R1 crit", crit_err, 0);
    chk("R1 debug", in_debug, 0);
    chk("R1 dbgreq", dbg_req, 0);
    chk("R1 nodt status", n_st_rd, 6'b000000);
  endtask

  task automatic t_status_write();
    do_reset();
    wr_st(6'b000001);
    chk("R2 plain write", st_rd, 6'b000001);
    wr_st(6'b010001);
    chk("R2 mdt forces mie off", st_rd, 6'b010000);
    wr_st(6'b100110);
    chk("R2 other fields", st_rd, 6'b100110);
  endtask

  task automatic t_trap();
    do_reset();
    wr_tvec(32'h1001);
    wr_st(6'b000001);
    do_trap(1'b0, 5'd2, 32'h400, 2'd1);
    chk("R3 status after trap", st_rd, 6'b010110);
    chk("R3 epc", epc_rd, 32'h400);
    chk("R3 cause", cause_rd, 6'd2);
    chk("R4 redirect", redirect, 1);
    chk("R4 exception base", redirect_pc, 32'h1000);
    @(negedge clk);
    chk("R4 single pulse", redirect, 0);
    do_ret(0, 2'd3, 2'd3);
    chk("R8 mret", st_rd, 6'b000011);
    do_trap(1'b1, 5'd3, 32'h500, 2'd3);
    chk("R3 status irq", st_rd, 6'b011110);
    chk("R3 cause irq", cause_rd, 6'h23);
    chk("R4 vectored irq", redirect_pc, 32'h100C);
  endtask

  task automatic t_vector();
    do_reset();
    wr_tvec(32'h2000);
    wr_st(6'b000000);
    do_trap(1'b1, 5'd5, 32'h10, 2'd3);
    chk("R4 direct irq", redirect_pc, 32'h2000);
    do_ret(0, 2'd3, 2'd3);
    wr_tvec(32'h3001);
    do_trap(1'b0, 5'd6, 32'h14, 2'd3);
    chk("R4 vectored exception", redirect_pc, 32'h3000);
  endtask

  task automatic t_double();
    do_reset();
    wr_tvec(32'h1000);
    do_trap(1'b0, 5'd1, 32'h88, 2'd3);
    chk("R5 crit set", crit_err, 1);
    chk("R5 no redirect", redirect, 0);
    chk("R5 epc kept", epc_rd, 0);
    chk("R5 cause kept", cause_rd, 0);
    chk("R5 status kept", st_rd, 6'b010000);
    chk("R7 dbgreq", dbg_req, 1);
    chk("R7 halt cause", dbg_cause, 3'd5);
    chk("R7 ext", dbg_extcause, 3'd0);
    do_trap(1'b0, 5'd4, 32'h99, 2'd3);
    chk("R6 trap ignored", epc_rd, 0);
    chk("R6 crit held", crit_err, 1);
    dbg_ack = 1; @(negedge clk); dbg_ack = 0;
    chk("R6 ack clears crit", crit_err, 0);
    chk("R7 in debug", in_debug, 1);
    chk("R7 latched cause", dbg_last_cause, 3'd5);
    do_trap(1'b0, 5'd4, 32'h77, 2'd3);
    chk("R6 trap ignored in debug", epc_rd, 0);
  endtask

  task automatic t_nmi();
    do_reset();
    wr_st(6'b000000);
    nmi_en = 0;
    do_trap(1'b0, 5'd2, 32'h44, 2'd3);
    nmi_en = 1;
    chk("R5 nmi low crit", crit_err, 1);
    chk("R5 nmi low status", st_rd, 6'b000000);
    chk("R5 nmi low epc", epc_rd, 0);
  endtask

  task automatic t_cetrig();
    do_reset();
    cet_we = 1; cet_wd = 1; @(negedge clk); cet_we = 0;
    chk("R7 cetrig write", cetrig_rd, 1);
    do_trap(1'b0, 5'd1, 32'h50, 2'd3);
    grp_halt = 1; #1;
    chk("R7 crit trigger cause", dbg_cause, 3'd7);
    chk("R7 crit ext", dbg_extcause, 3'd0);
    dbg_ack = 1; @(negedge clk); dbg_ack = 0; grp_halt = 0;
    chk("R7 latched ext cause", dbg_last_cause, 3'd7);
    do_ret(2, 2'd3, 2'd3);
    chk("R10 left debug", in_debug, 0);
    grp_halt = 1; step_done = 1; #1;
    chk("R7 group cause", dbg_cause, 3'd6);
    grp_halt = 0; #1;
    chk("R7 step cause", dbg_cause, 3'd4);
    chk("R7 step ext", dbg_extcause, 3'd0);
    dbg_ack = 1; @(negedge clk); dbg_ack = 0; step_done = 0;
    chk("R7 step latched", dbg_last_cause, 3'd4);
  endtask

  task automatic t_sret();
    do_reset();
    do_ret(1, 2'd1, 2'd3);
    chk("R9 sret below M keeps", st_rd, 6'b010000);
    do_ret(1, 2'd3, 2'd3);
    chk("R9 sret in M clears", st_rd, 6'b000000);
  endtask

  task automatic t_dret();
    do_reset();
    wr_st(6'b110000);
    grp_halt = 1; dbg_ack = 1; @(negedge clk); grp_halt = 0; dbg_ack = 0;
    chk("R10 entered", in_debug, 1);
    do_ret(2, 2'd3, 2'd3);
    chk("R10 dret to M keeps", st_rd, 6'b110000);
    chk("R10 exit", in_debug, 0);
    grp_halt = 1; dbg_ack = 1; @(negedge clk); grp_halt = 0; dbg_ack = 0;
    do_ret(2, 2'd3, 2'd0);
    chk("R10 dret to U clears", st_rd, 6'b000000);
  endtask

  task automatic t_prio();
    do_reset();
    wr_st(6'b000001);
    st_we = 1; st_wd = 6'b100000;
    do_trap(1'b0, 5'd0, 32'h60, 2'd3);
    st_we = 0;
    chk("R12 trap wins", st_rd, 6'b011110);
    chk("R12 redirect", redirect, 1);
  endtask

  task automatic t_nodt();
    do_reset();
    cet_we = 1; cet_wd = 1; @(negedge clk); cet_we = 0;
    chk("R11 cetrig ignored", n_cetrig_rd, 0);
    wr_st(6'b010001);
    chk("R11 mdt ignored", n_st_rd, 6'b000001);
    do_trap(1'b0, 5'd2, 32'h80, 2'd3);
    chk("R11 first trap", n_st_rd, 6'b001110);
    do_trap(1'b0, 5'd3, 32'h84, 2'd3);
    chk("R11 second trap vectors", n_redirect, 1);
    chk("R11 no crit", n_crit_err, 0);
    nmi_en = 0;
    do_trap(1'b0, 5'd4, 32'h88, 2'd3);
    nmi_en = 1;
    chk("R11 nmi low vectors", n_epc_rd, 32'h88);
    chk("R11 nmi low no crit", n_crit_err, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    t_reset();
    t_status_write();
    t_trap();
    t_vector();
    t_double();
    t_nmi();
    t_cetrig();
    t_sret();
    t_dret();
    t_prio();
    t_nodt();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule